// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window that lets a host processor pass a command and up to 16 bytes of payload to a remote controller, then collect the outcome and up to 16 bytes of reply. The host sees a 32-bit register bus over a 256-byte window. It writes the payload words, then writes a packed command word. The remote side gets a one-cycle doorbell and reads the latched command and the payload words through its own index port. It writes reply words into a second buffer and then signals done, with an error flag, an error code and an initiator id.

The host learns of completion in one of two ways. It can poll the busy bit in the status word. If it set the completion-interrupt flag in the command, it also gets a one-cycle interrupt pulse, which needs no clearing. The status word keeps the outcome until the next accepted command. A command written while a previous one is still pending is dropped, and a sticky overrun bit records the drop.

Top module: `mbox_regs`

## Requirements
- R1: After reset, the status word (offset 0x04) reads 0, every read-buffer word reads 0, every write-buffer word seen by the remote is 0, and doorbell_o and host_irq_o are low.
- R2: A host write to offset 0x00 while status bit 0 (busy) is clear is accepted. Busy reads 1 after that clock edge. doorbell_o pulses high for exactly one cycle. rmt_cmd_o holds the written word. Status bits 7:4 show command bits 15:12. Status bit 1 (error) and status bits 23:16 (error code) clear to 0.
- R3: A host write to offset 0x00 while busy is set leaves rmt_cmd_o unchanged and raises no doorbell. It sets status bit 2 (overrun), which then stays 1 across later commands and completions until reset.
- R4: rmt_done_i high for one cycle while busy clears busy. It loads status bit 1 from rmt_err_i, status bits 23:16 from rmt_code_i and status bits 15:8 from rmt_init_i.
- R5: rmt_done_i while busy is clear has no effect on the status word and raises no host interrupt.
- R6: On the cycle after an accepted completion, host_irq_o is high for exactly one cycle if bit 8 of the latched command is set. It stays low if that bit is clear.
- R7: Host word writes to offsets 0x80, 0x84, 0x88 and 0x8C fill write-buffer words 0 to 3, which the remote reads at rmt_widx_i. Host reads of 0x80 to 0x8F return 0.
- R8: A remote write of word k through rmt_ridx_i is read by the host at offset 0x90+4k. When hbyte_i is 1, the read returns the byte in lane haddr_i[1:0] (lane 0 = bits 7:0) in bits 7:0, with the upper bits 0.
- R9: Host reads of the command offset and of unmapped offsets return 0. Host writes to the status offset or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hwr_i | input | 1 | Host write strobe |
| haddr_i | input | 8 | Host byte address in the window |
| hwdata_i | input | 32 | Host write data |
| hbyte_i | input | 1 | Host read width: 1 = byte, 0 = word |
| hrdata_o | output | 32 | Host read data, combinational from address |
| host_irq_o | output | 1 | One-cycle completion pulse |
| doorbell_o | output | 1 | One-cycle pulse to remote on accepted command |
| rmt_cmd_o | output | 32 | Latched command word |
| rmt_widx_i | input | 2 | Remote write-buffer word index |
| rmt_wdata_o | output | 32 | Write-buffer word at rmt_widx_i |
| rmt_rwe_i | input | 1 | Remote read-buffer write enable |
| rmt_ridx_i | input | 2 | Remote read-buffer word index |
| rmt_rdata_i | input | 32 | Remote read-buffer write data |
| rmt_done_i | input | 1 | Remote completion strobe |
| rmt_err_i | input | 1 | Error flag sampled at completion |
| rmt_code_i | input | 8 | Error code sampled at completion |
| rmt_init_i | input | 8 | Initiator id sampled at completion |

## Verification
A busy flag stuck high or low shows up on the next status read and on a missing or extra doorbell within one cycle of the command write. A wrong latched command would show as a stale sub-command field and a wrong interrupt decision at the next completion. Buffer index or byte-lane errors show as a mismatch on the first sweep word or byte that lands in the wrong slot. A pulse held too long or dropped changes the pulse counts the bench keeps, which are compared after every transaction.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STS  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_WBUF = 8'h80;
  localparam logic [ADDR_W-1:0] OFF_RBUF = 8'h90;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] code;
  } cmd_t;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] code;
    logic [7:0] init;
    logic [3:0] sub;
    logic       rsv_lo;
    logic       ovr;
    logic       err;
    logic       busy;
  } sts_t;
endpackage

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (we_i && widx_i == IW'(i))       mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  cmd_t       cmd_i,
  input  logic       done_i,
  input  logic       err_i,
  input  logic [7:0] code_i,
  input  logic [7:0] init_i,
  output cmd_t       cmd_o,
  output sts_t       sts_o,
  output logic       doorbell_o,
  output logic       irq_o
);
  cmd_t       cmd_q;
  logic       busy_q, err_q, ovr_q, db_q, irq_q;
  logic [7:0] code_q, init_q;
  logic       accept, finish;

  assign accept = cmd_we_i && !busy_q;
  assign finish = done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      code_q <= '0;
      init_q <= '0;
      db_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      db_q  <= accept;
      irq_q <= finish && cmd_q.ioc;
      if (cmd_we_i && busy_q) ovr_q <= 1'b1;
      if (accept) begin
        cmd_q  <= cmd_i;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= code_i;
        init_q <= init_i;
      end
    end
  end

  always_comb begin
    sts_o        = '0;
    sts_o.busy   = busy_q;
    sts_o.err    = err_q;
    sts_o.ovr    = ovr_q;
    sts_o.sub    = cmd_q.sub;
    sts_o.init   = init_q;
    sts_o.code   = code_q;
  end

  assign cmd_o      = cmd_q;
  assign doorbell_o = db_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux #(
  parameter int unsigned DW = 32
) (
  input  logic          sts_hit_i,
  input  logic          rbuf_hit_i,
  input  logic          byte_i,
  input  logic [1:0]    lane_i,
  input  logic [DW-1:0] sts_i,
  input  logic [DW-1:0] rbuf_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] word;

  always_comb begin
    if (sts_hit_i)       word = sts_i;
    else if (rbuf_hit_i) word = rbuf_i;
    else                 word = '0;
    if (byte_i) rdata_o = {{(DW-8){1'b0}}, word[8*lane_i +: 8]};
    else        rdata_o = word;
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned IW       = $clog2(BUF_WORDS),
  localparam int unsigned BLK_LSB  = IW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hwr_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [31:0]       hwdata_i,
  input  logic              hbyte_i,
  output logic [31:0]       hrdata_o,
  output logic              host_irq_o,
  output logic              doorbell_o,
  output logic [31:0]       rmt_cmd_o,
  input  logic [IW-1:0]     rmt_widx_i,
  output logic [31:0]       rmt_wdata_o,
  input  logic              rmt_rwe_i,
  input  logic [IW-1:0]     rmt_ridx_i,
  input  logic [31:0]       rmt_rdata_i,
  input  logic              rmt_done_i,
  input  logic              rmt_err_i,
  input  logic [7:0]        rmt_code_i,
  input  logic [7:0]        rmt_init_i
);
  logic          cmd_hit, sts_hit, wbuf_hit, rbuf_hit;
  logic [IW-1:0] hidx;
  logic [31:0]   rbuf_word;
  cmd_t          cmd_w;
  sts_t          sts_w;

  assign cmd_hit  = haddr_i[ADDR_W-1:2] == OFF_CMD[ADDR_W-1:2];
  assign sts_hit  = haddr_i[ADDR_W-1:2] == OFF_STS[ADDR_W-1:2];
  assign wbuf_hit = haddr_i[ADDR_W-1:BLK_LSB] == OFF_WBUF[ADDR_W-1:BLK_LSB];
  assign rbuf_hit = haddr_i[ADDR_W-1:BLK_LSB] == OFF_RBUF[ADDR_W-1:BLK_LSB];
  assign hidx     = haddr_i[BLK_LSB-1:2];

  mbox_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i  (hwr_i && cmd_hit),
    .cmd_i     (cmd_t'(hwdata_i)),
    .done_i    (rmt_done_i),
    .err_i     (rmt_err_i),
    .code_i    (rmt_code_i),
    .init_i    (rmt_init_i),
    .cmd_o     (cmd_w),
    .sts_o     (sts_w),
    .doorbell_o(doorbell_o),
    .irq_o     (host_irq_o)
  );

  mbox_wordbuf #(.WORDS(BUF_WORDS), .DW(32)) u_wbuf (
    .clk_i, .rst_ni,
    .we_i   (hwr_i && wbuf_hit),
    .widx_i (hidx),
    .wdata_i(hwdata_i),
    .ridx_i (rmt_widx_i),
    .rdata_o(rmt_wdata_o)
  );

  mbox_wordbuf #(.WORDS(BUF_WORDS), .DW(32)) u_rbuf (
    .clk_i, .rst_ni,
    .we_i   (rmt_rwe_i),
    .widx_i (rmt_ridx_i),
    .wdata_i(rmt_rdata_i),
    .ridx_i (hidx),
    .rdata_o(rbuf_word)
  );

  mbox_rdmux #(.DW(32)) u_rdmux (
    .sts_hit_i (sts_hit),
    .rbuf_hit_i(rbuf_hit),
    .byte_i    (hbyte_i),
    .lane_i    (haddr_i[1:0]),
    .sts_i     (sts_w),
    .rbuf_i    (rbuf_word),
    .rdata_o   (hrdata_o)
  );

  assign rmt_cmd_o = cmd_w;
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hwr_i,
  input logic [ADDR_W-1:0] haddr_i,
  input logic [31:0]       hwdata_i,
  input logic [31:0]       sts_i,
  input logic [31:0]       rmt_cmd_o,
  input logic              doorbell_o,
  input logic              host_irq_o,
  input logic              rmt_done_i,
  input logic              rmt_err_i,
  input logic [7:0]        rmt_code_i
);
  logic cmd_wr;
  assign cmd_wr = hwr_i && haddr_i[ADDR_W-1:2] == '0;

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !sts_i[0]) |=> (sts_i[0] && doorbell_o && rmt_cmd_o == $past(hwdata_i)));
  // R3
  busy_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && sts_i[0]) |=> (sts_i[2] && !doorbell_o && $stable(rmt_cmd_o)));
  // R3
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_i[2] |=> sts_i[2]);
  // R4
  done_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmt_done_i && sts_i[0]) |=>
      (!sts_i[0] && sts_i[1] == $past(rmt_err_i) && sts_i[23:16] == $past(rmt_code_i)));
  // R5
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmt_done_i && !sts_i[0] && !cmd_wr) |=> $stable(sts_i));
  // R6
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |=> !host_irq_o);
  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> ($past(rmt_done_i) && $past(sts_i[0]) && $past(rmt_cmd_o[8])));
  // R2
  doorbell_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_o |=> !doorbell_o);
endmodule

bind mbox_regs mbox_regs_chk #(.ADDR_W(mbox_pkg::ADDR_W)) u_chk (
  .clk_i, .rst_ni, .hwr_i, .haddr_i, .hwdata_i,
  .sts_i(sts_w), .rmt_cmd_o, .doorbell_o, .host_irq_o,
  .rmt_done_i, .rmt_err_i, .rmt_code_i
);

// File: tb/mbox_regs_tb_top.sv
module mbox_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hwr_i = 1'b0;
  logic [7:0]  haddr_i = '0;
  logic [31:0] hwdata_i = '0;
  logic        hbyte_i = 1'b0;
  logic [31:0] hrdata_o;
  logic        host_irq_o, doorbell_o;
  logic [31:0] rmt_cmd_o, rmt_wdata_o;
  logic [1:0]  rmt_widx_i = '0, rmt_ridx_i = '0;
  logic        rmt_rwe_i = 1'b0;
  logic [31:0] rmt_rdata_i = '0;
  logic        rmt_done_i = 1'b0, rmt_err_i = 1'b0;
  logic [7:0]  rmt_code_i = '0, rmt_init_i = '0;

  int errors = 0, checks = 0, db_cnt = 0, irq_cnt = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  mbox_regs dut_i (.*);

  always @(negedge clk_i) begin
    if (doorbell_o) db_cnt++;
    if (host_irq_o) irq_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); hwr_i = 1'b1; haddr_i = a; hwdata_i = d;
    @(negedge clk_i); hwr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic hrd(input logic [7:0] a, input logic b, output logic [31:0] d);
    @(negedge clk_i); haddr_i = a; hbyte_i = b;
    #1 d = hrdata_o;
  endtask

  task automatic rdone(input logic e, input logic [7:0] c, input logic [7:0] id);
    @(negedge clk_i); rmt_done_i = 1'b1; rmt_err_i = e; rmt_code_i = c; rmt_init_i = id;
    @(negedge clk_i); rmt_done_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic rwr(input logic [1:0] k, input logic [31:0] d);
    @(negedge clk_i); rmt_rwe_i = 1'b1; rmt_ridx_i = k; rmt_rdata_i = d;
    @(negedge clk_i); rmt_rwe_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  function automatic logic [31:0] sts_exp(logic [7:0] code, logic [7:0] init, logic [3:0] sub,
                                          logic ovr, logic err, logic busy);
    return {8'h00, code, init, sub, 1'b0, ovr, err, busy};
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, cmd, prev_cmd;
    logic [7:0]  last_init;
    int db0, irq0;
    do_reset();

    // R1 reset state
    hrd(8'h04, 1'b0, d); chk("R1 status", d, 32'h0);
    for (int k = 0; k < 4; k++) begin
      hrd(8'h90 + 8'(4*k), 1'b0, d); chk("R1 rbuf", d, 32'h0);
      rmt_widx_i = 2'(k); #1 chk("R1 wbuf", rmt_wdata_o, 32'h0);
    end
    chk("R1 pulses", {30'h0, doorbell_o, host_irq_o}, 32'h0);

    // R7 write buffer sweep
    for (int k = 0; k < 4; k++) hwr(8'h80 + 8'(4*k), 32'hA5000000 ^ (32'(k) * 32'h01030507));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); rmt_widx_i = 2'(k);
      #1 chk("R7 remote word", rmt_wdata_o, 32'hA5000000 ^ (32'(k) * 32'h01030507));
      hrd(8'h80 + 8'(4*k), 1'b0, d); chk("R7 host read zero", d, 32'h0);
    end

    // R8 read buffer sweep, words and all bytes
    for (int k = 0; k < 4; k++) rwr(2'(k), 32'h11223344 + 32'(k) * 32'h10203040);
    for (int k = 0; k < 4; k++) begin
      hrd(8'h90 + 8'(4*k), 1'b0, d); chk("R8 word", d, 32'h11223344 + 32'(k) * 32'h10203040);
    end
    for (int b = 0; b < 16; b++) begin
      logic [31:0] w;
      w = 32'h11223344 + 32'(b / 4) * 32'h10203040;
      hrd(8'h90 + 8'(b), 1'b1, d); chk("R8 byte", d, (w >> (8 * (b % 4))) & 32'hFF);
    end

    // R9 write-only and unmapped reads, ignored writes
    hwr(8'h04, 32'hFFFFFFFF);
    hwr(8'h40, 32'hFFFFFFFF);
    hrd(8'h04, 1'b0, d); chk("R9 status untouched", d, 32'h0);
    hrd(8'h40, 1'b0, d); chk("R9 unmapped read", d, 32'h0);
    chk("R9 no doorbell", db_cnt, 0);

    // R2 R4 R6 command sweep
    last_init = 8'h00;
    for (int n = 0; n < 16; n++) begin
      cmd = {8'h00, 8'(2*n), 4'(n), 3'b000, 1'(n), 8'hF0 + 8'(n)};
      db0 = db_cnt; irq0 = irq_cnt;
      hwr(8'h00, cmd);
      chk("R2 doorbell once", db_cnt, db0 + 1);
      chk("R2 latched cmd", rmt_cmd_o, cmd);
      hrd(8'h00, 1'b0, d); chk("R9 cmd read zero", d, 32'h0);
      hrd(8'h04, 1'b0, d); chk("R2 busy status", d, sts_exp(8'h0, last_init, 4'(n), 1'b0, 1'b0, 1'b1));
      rdone(1'(n >> 1), 8'(7*n + 1), 8'h40 + 8'(n));
      last_init = 8'h40 + 8'(n);
      hrd(8'h04, 1'b0, d);
      chk("R4 done status", d, sts_exp(8'(7*n + 1), last_init, 4'(n), 1'b0, 1'(n >> 1), 1'b0));
      chk("R6 irq count", irq_cnt, irq0 + (n % 2));
    end

    // R5 done while idle
    hrd(8'h04, 1'b0, d); prev_cmd = d; irq0 = irq_cnt;
    rdone(1'b0, 8'h5A, 8'h99);
    hrd(8'h04, 1'b0, d); chk("R5 idle done status", d, prev_cmd);
    chk("R5 idle done irq", irq_cnt, irq0);

    // R3 overrun
    cmd = 32'h0003_5101;
    hwr(8'h00, cmd);
    db0 = db_cnt;
    hwr(8'h00, 32'h00FF_F1EE);
    chk("R3 cmd kept", rmt_cmd_o, cmd);
    chk("R3 no doorbell", db_cnt, db0);
    hrd(8'h04, 1'b0, d); chk("R3 overrun busy", d, sts_exp(8'h0, last_init, 4'h5, 1'b1, 1'b0, 1'b1));
    rdone(1'b1, 8'h33, 8'h21);
    hrd(8'h04, 1'b0, d); chk("R3 overrun after done", d, sts_exp(8'h33, 8'h21, 4'h5, 1'b1, 1'b1, 1'b0));
    hwr(8'h00, 32'h0000_2002);
    hrd(8'h04, 1'b0, d); chk("R3 overrun sticky", d, sts_exp(8'h00, 8'h21, 4'h2, 1'b1, 1'b0, 1'b1));
    do_reset();
    hrd(8'h04, 1'b0, d); chk("R1 R3 cleared by reset", d, 32'h0);
    hrd(8'h94, 1'b0, d); chk("R1 rbuf cleared", d, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule